// File: doc/BRIEF.md
# Configuration Readback Serial Streamer

This block sends the contents of a frame-organised configuration store, including any captured state bits held there, out over one serial line. It runs on a readback clock supplied by the user. A transfer starts when a trigger input is sampled high and configuration has completed. The block fetches stored bits through a simple synchronous read port and adds a fixed framing around them. The framing has a run of high lead-in bits, a low start bit before every frame, high check slots after every frame, forced-high bits at the head of the first frame and at the tail of the last one, and a closing start bit followed by an 11-bit signature. An in-progress flag is high for the whole transfer.

The sequencer walks through these named states: `ST_IDLE`, `ST_LAUNCH`, `ST_DUMMY`, `ST_FSTART`, `ST_DATA`, `ST_CHECK`, `ST_TSTART` and `ST_SIG`. The transitions are:
- `ST_IDLE` to `ST_LAUNCH` on an accepted trigger.
- `ST_LAUNCH` to `ST_DUMMY` unconditionally.
- `ST_DUMMY` to `ST_FSTART` after five bits.
- `ST_FSTART` to `ST_DATA` unconditionally.
- `ST_DATA` to `ST_CHECK` after `FRAME_BITS` bits.
- `ST_CHECK` to `ST_FSTART` after four bits when another frame remains, or to `ST_TSTART` after the last frame.
- `ST_TSTART` to `ST_SIG` unconditionally.
- `ST_SIG` to `ST_IDLE` after eleven bits.

The frame count `N_FRAMES` and the data bits per frame `FRAME_BITS` are parameters. `FRAME_BITS` must be at least 5.

Top module: `cfg_readback_streamer`

## Requirements
- R1: When idle, armed and `cfg_done` is high, a rising clock edge that samples `trig` high sets `in_progress`. In the cycle that follows, `ser_out` stays high. While `cfg_done` is low, no transfer starts.
- R2: After that launch cycle, each rising edge presents the next stream bit on `ser_out`. The order is: five 1s, then for each frame a 0 start bit, `FRAME_BITS` data bits, and four check slots. Data bit i of frame f is the stored bit at address f*FRAME_BITS+i, output non-inverted.
- R3: The first two data bits of frame 0 are output as 1, whatever the store holds.
- R4: The last seven bit positions of the final frame are output as 1. These are its last three data bits and its four check slots.
- R5: Every check slot of every frame is output as 1.
- R6: After the final frame comes one 0 start bit, then the 11 signature bits. `in_progress` falls on the edge after the last signature bit, so it is high for exactly 5+N_FRAMES*(FRAME_BITS+5)+13 cycles.
- R7: The signature register is cleared when a transfer starts. It is then stepped once per emitted data bit, using the value actually output (after forcing), with the polynomial x^11+x^9+x^8+1. The step is: feedback = msb XOR bit; shift left; if feedback is 1, XOR with 0x301. The signature is sent MSB first.
- R8: A trigger that is held or reasserted during a transfer is ignored. A new transfer needs `trig` to be sampled low while idle and then high again.
- R9: While idle, `ser_out` is 1. A synchronous `rst` returns the block to idle with `in_progress` low and the trigger disarmed.
- R10: The read port is synchronous with one cycle of latency. `rd_addr` steps through addresses 0 to N_FRAMES*FRAME_BITS-1 in order and never leaves that range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readback clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_done | input | 1 | Configuration has completed |
| trig | input | 1 | Readback trigger |
| rd_addr | output | ADDR_W | Store read address |
| rd_data | input | 1 | Stored bit, valid one cycle after address |
| ser_out | output | 1 | Serial readback data |
| in_progress | output | 1 | Transfer in progress |

## Verification
The bench builds the block with three frames of ten data bits each. This is small enough that a whole 62-bit stream runs in well under a hundred cycles, yet it still contains a middle frame that is neither first nor last. That middle frame separates the head forcing from the tail forcing and the ordinary data path. With this size, all-zero, all-one and random store contents can each be run several times. The same size also brings the signature rollover, the back-to-back retrigger gap and a reset in mid-stream within reach.

// File: rtl/rb_pkg.sv
package rb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_DUMMY,
        ST_FSTART,
        ST_DATA,
        ST_CHECK,
        ST_TSTART,
        ST_SIG
    } rb_state_e;

    localparam int LEAD_BITS  = 5;
    localparam int CHECK_BITS = 4;
    localparam int SIG_BITS   = 11;
    localparam int HEAD_HIGH  = 2;
    localparam int TAIL_DATA_HIGH = 3;
    localparam logic [SIG_BITS-1:0] SIG_POLY = 11'h301;

    function automatic logic [SIG_BITS-1:0] sig_step(input logic [SIG_BITS-1:0] cur,
                                                     input logic bit_in);
        logic fb;
        logic [SIG_BITS-1:0] nxt;
        fb  = cur[SIG_BITS-1] ^ bit_in;
        nxt = {cur[SIG_BITS-2:0], 1'b0};
        if (fb) nxt = nxt ^ SIG_POLY;
        return nxt;
    endfunction

endpackage

// File: rtl/rb_trig_arm.sv
module rb_trig_arm (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic cfg_done,
    input  logic idle,
    output logic start
);
    logic armed_q;

    assign start = idle && cfg_done && trig && armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (start) begin
            armed_q <= 1'b0;
        end else if (idle && !trig) begin
            armed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/rb_sig11.sv
module rb_sig11
    import rb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic upd,
    input  logic din,
    input  logic shift,
    output logic msb
);
    logic [SIG_BITS-1:0] sig_q;

    assign msb = sig_q[SIG_BITS-1];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sig_q <= '0;
        end else if (upd) begin
            sig_q <= sig_step(sig_q, din);
        end else if (shift) begin
            sig_q <= {sig_q[SIG_BITS-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/rb_seq.sv
module rb_seq
    import rb_pkg::*;
#(
    parameter int N_FRAMES   = 8,
    parameter int FRAME_BITS = 16,
    parameter int ADDR_W     = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              rd_data,
    input  logic              sig_msb,
    output rb_state_e         state,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              ser_out,
    output logic              busy,
    output logic              sig_upd,
    output logic              sig_shift
);
    localparam int MAXSEG = (FRAME_BITS > SIG_BITS) ? FRAME_BITS : SIG_BITS;
    localparam int CW = $clog2(MAXSEG);
    localparam int FW = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1;
    localparam logic [CW-1:0] LEAD_LAST  = CW'(LEAD_BITS - 1);
    localparam logic [CW-1:0] DATA_LAST  = CW'(FRAME_BITS - 1);
    localparam logic [CW-1:0] CHECK_LAST = CW'(CHECK_BITS - 1);
    localparam logic [CW-1:0] SIG_LAST   = CW'(SIG_BITS - 1);
    localparam logic [CW-1:0] HEAD_END   = CW'(HEAD_HIGH);
    localparam logic [CW-1:0] TAIL_FROM  = CW'(FRAME_BITS - TAIL_DATA_HIGH);
    localparam logic [FW-1:0] FRAME_LAST = FW'(N_FRAMES - 1);
    localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(N_FRAMES * FRAME_BITS - 1);

    rb_state_e         st_q, st_d;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic [FW-1:0]     frm_q, frm_d;
    logic [ADDR_W-1:0] adr_q, adr_d;
    logic              force_hi;

    assign state   = st_q;
    assign rd_addr = adr_q;

    // next-state and counter logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        frm_d = frm_q;
        adr_d = adr_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    st_d  = ST_LAUNCH;
                    cnt_d = '0;
                    frm_d = '0;
                    adr_d = '0;
                end
            end
            ST_LAUNCH: begin
                st_d  = ST_DUMMY;
                cnt_d = '0;
            end
            ST_DUMMY: begin
                if (cnt_q == LEAD_LAST) begin
                    st_d = ST_FSTART;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_FSTART: begin
                st_d  = ST_DATA;
                cnt_d = '0;
                if (adr_q != ADDR_LAST) adr_d = adr_q + 1'b1;
            end
            ST_DATA: begin
                if (cnt_q == DATA_LAST) begin
                    st_d  = ST_CHECK;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                    if (adr_q != ADDR_LAST) adr_d = adr_q + 1'b1;
                end
            end
            ST_CHECK: begin
                if (cnt_q == CHECK_LAST) begin
                    cnt_d = '0;
                    if (frm_q == FRAME_LAST) begin
                        st_d = ST_TSTART;
                    end else begin
                        st_d  = ST_FSTART;
                        frm_d = frm_q + 1'b1;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_TSTART: begin
                st_d  = ST_SIG;
                cnt_d = '0;
            end
            ST_SIG: begin
                if (cnt_q == SIG_LAST) begin
                    st_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            frm_q <= '0;
            adr_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            frm_q <= frm_d;
            adr_q <= adr_d;
        end
    end

    // outputs
    always_comb begin
        force_hi  = ((frm_q == '0) && (cnt_q < HEAD_END)) ||
                    ((frm_q == FRAME_LAST) && (cnt_q >= TAIL_FROM));
        busy      = (st_q != ST_IDLE);
        sig_upd   = 1'b0;
        sig_shift = 1'b0;
        ser_out   = 1'b1;
        unique case (st_q)
            ST_IDLE, ST_LAUNCH, ST_DUMMY, ST_CHECK: ser_out = 1'b1;
            ST_FSTART, ST_TSTART:                   ser_out = 1'b0;
            ST_DATA: begin
                ser_out = force_hi ? 1'b1 : rd_data;
                sig_upd = 1'b1;
            end
            ST_SIG: begin
                ser_out   = sig_msb;
                sig_shift = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/cfg_readback_streamer.sv
module cfg_readback_streamer
    import rb_pkg::*;
#(
    parameter int N_FRAMES   = 8,
    parameter int FRAME_BITS = 16,
    localparam int ADDR_W    = $clog2(N_FRAMES * FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_done,
    input  logic              trig,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_data,
    output logic              ser_out,
    output logic              in_progress
);
    rb_state_e st;
    logic      start;
    logic      sig_msb;
    logic      sig_upd;
    logic      sig_shift;

    rb_trig_arm u_arm (
        .clk      (clk),
        .rst      (rst),
        .trig     (trig),
        .cfg_done (cfg_done),
        .idle     (st == ST_IDLE),
        .start    (start)
    );

    rb_seq #(
        .N_FRAMES   (N_FRAMES),
        .FRAME_BITS (FRAME_BITS),
        .ADDR_W     (ADDR_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .rd_data   (rd_data),
        .sig_msb   (sig_msb),
        .state     (st),
        .rd_addr   (rd_addr),
        .ser_out   (ser_out),
        .busy      (in_progress),
        .sig_upd   (sig_upd),
        .sig_shift (sig_shift)
    );

    rb_sig11 u_sig (
        .clk   (clk),
        .rst   (rst),
        .clr   (start),
        .upd   (sig_upd),
        .din   (ser_out),
        .shift (sig_shift),
        .msb   (sig_msb)
    );
endmodule

// File: rtl/rb_stream_chk.sv
module rb_stream_chk
    import rb_pkg::*;
#(
    parameter int N_FRAMES   = 8,
    parameter int FRAME_BITS = 16,
    parameter int ADDR_W     = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_done,
    input logic              trig,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              ser_out,
    input logic              in_progress,
    input rb_state_e         st
);
    localparam int BUSY_LEN = LEAD_BITS + N_FRAMES * (FRAME_BITS + 1 + CHECK_BITS)
                              + 1 + SIG_BITS + 1;
    localparam int DEPTH = N_FRAMES * FRAME_BITS;

    int unsigned busy_cnt;
    always_ff @(posedge clk) begin
        if (rst || !in_progress) busy_cnt <= 0;
        else                     busy_cnt <= busy_cnt + 1;
    end

    a_r1_no_start_unconfigured: assert property (@(posedge clk) disable iff (rst)
        (!in_progress && !cfg_done) |=> !in_progress);

    a_r1_launch_high: assert property (@(posedge clk) disable iff (rst)
        ($rose(in_progress) && !$past(rst)) |-> (ser_out && $past(trig)));

    a_r5_check_high: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CHECK) |-> ser_out);

    a_r6_start_low: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FSTART || st == ST_TSTART) |-> !ser_out);

    a_r6_busy_length: assert property (@(posedge clk) disable iff (rst)
        ($fell(in_progress) && !$past(rst)) |-> (busy_cnt == BUSY_LEN));

    a_r8_gap: assert property (@(posedge clk) disable iff (rst)
        ($fell(in_progress) && !$past(rst)) |=> !in_progress);

    a_r9_idle_high: assert property (@(posedge clk) disable iff (rst)
        !in_progress |-> ser_out);

    a_r10_addr_range: assert property (@(posedge clk) disable iff (rst)
        int'(rd_addr) < DEPTH);
endmodule

bind cfg_readback_streamer rb_stream_chk #(
    .N_FRAMES   (N_FRAMES),
    .FRAME_BITS (FRAME_BITS),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_done    (cfg_done),
    .trig        (trig),
    .rd_addr     (rd_addr),
    .ser_out     (ser_out),
    .in_progress (in_progress),
    .st          (st)
);

// File: tb/sim_cfg_readback_streamer.sv
module sim_cfg_readback_streamer;
    localparam int NF = 3;
    localparam int FB = 10;
    localparam int AW = $clog2(NF * FB);
    localparam int L  = 5 + NF * (FB + 5) + 12;

    logic clk = 1'b0;
    logic rst, cfg_done, trig, rd_data, ser_out, in_progress;
    logic [AW-1:0] rd_addr;
    logic [NF*FB-1:0] mem;

    bit    exp_b [L];
    string exp_t [L];
    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cfg_readback_streamer #(.N_FRAMES(NF), .FRAME_BITS(FB)) u0 (
        .clk(clk), .rst(rst), .cfg_done(cfg_done), .trig(trig),
        .rd_addr(rd_addr), .rd_data(rd_data), .ser_out(ser_out),
        .in_progress(in_progress)
    );

    // synchronous store model, one cycle latency (R10)
    always @(posedge clk) rd_data <= mem[rd_addr];

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic logic [10:0] sig_next(input logic [10:0] c, input bit b);
        logic [10:0] n;
        n = {c[9:0], 1'b0};
        if (c[10] ^ b) n = n ^ 11'h301;
        return n;
    endfunction

    function automatic void build_exp();
        int p = 0;
        logic [10:0] sig = '0;
        for (int i = 0; i < 5; i++) begin exp_b[p] = 1; exp_t[p] = "R2 lead"; p++; end
        for (int f = 0; f < NF; f++) begin
            exp_b[p] = 0; exp_t[p] = "R2 start"; p++;
            for (int i = 0; i < FB; i++) begin
                bit b = mem[f*FB + i];
                exp_t[p] = "R2 data";
                if (f == 0 && i < 2)         begin b = 1; exp_t[p] = "R3 head"; end
                if (f == NF-1 && i >= FB-3)  begin b = 1; exp_t[p] = "R4 tail"; end
                exp_b[p] = b;
                sig = sig_next(sig, b);
                p++;
            end
            for (int i = 0; i < 4; i++) begin exp_b[p] = 1; exp_t[p] = "R5 check"; p++; end
        end
        exp_b[p] = 0; exp_t[p] = "R6 final start"; p++;
        for (int i = 10; i >= 0; i--) begin exp_b[p] = sig[i]; exp_t[p] = "R7 signature"; p++; end
    endfunction

    task automatic run_stream(input bit hold);
        build_exp();
        trig = 0;
        @(negedge clk);
        trig = 1;
        @(negedge clk);
        chk(in_progress === 1'b1, "R1 rip rises", in_progress, 1);
        chk(ser_out === 1'b1, "R1 launch bit high", ser_out, 1);
        if (!hold) trig = 0;
        for (int p = 0; p < L; p++) begin
            @(negedge clk);
            chk(ser_out === exp_b[p], exp_t[p], ser_out, exp_b[p]);
            if (in_progress !== 1'b1) chk(0, "R6 rip held", in_progress, 1);
        end
        @(negedge clk);
        chk(in_progress === 1'b0, "R6 rip falls", in_progress, 0);
        chk(ser_out === 1'b1, "R9 idle high", ser_out, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0413));
        rst = 1; cfg_done = 0; trig = 0; mem = '0;
        repeat (3) @(negedge clk);
        chk(in_progress === 1'b0, "R9 reset rip", in_progress, 0);
        chk(ser_out === 1'b1, "R9 reset out", ser_out, 1);
        rst = 0;
        @(negedge clk);

        // R1: no start before configuration completes
        trig = 1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(in_progress === 1'b0, "R1 unconfigured", in_progress, 0);
        end
        trig = 0;
        cfg_done = 1;
        @(negedge clk);

        // directed contents
        mem = '0;  run_stream(0);
        mem = '1;  run_stream(0);
        for (int i = 0; i < NF*FB; i++) mem[i] = i[0];
        run_stream(0);

        // random contents, random trigger holding
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < NF*FB; i++) mem[i] = 1'($urandom);
            run_stream(1'($urandom_range(0, 1)));
        end

        // R8: held trigger neither restarts nor retriggers
        for (int i = 0; i < NF*FB; i++) mem[i] = 1'($urandom);
        run_stream(1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(in_progress === 1'b0, "R8 held trigger ignored", in_progress, 0);
        end
        run_stream(0);

        // R9: reset in mid-stream
        trig = 0; @(negedge clk);
        trig = 1; @(negedge clk);
        trig = 0;
        repeat (20) @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        chk(in_progress === 1'b0, "R9 mid-run reset rip", in_progress, 0);
        chk(ser_out === 1'b1, "R9 mid-run reset out", ser_out, 1);
        rst = 0;
        trig = 1;
        repeat (3) @(negedge clk);
        chk(in_progress === 1'b0, "R9 disarmed after reset", in_progress, 0);
        for (int i = 0; i < NF*FB; i++) mem[i] = 1'($urandom);
        run_stream(0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule